// File: doc/BRIEF.md
# Address-Decoded Multi-Bank Memory

This block presents a single wide memory built from several identical RAM banks. The upper address bits choose one bank. The lower address bits form the word offset inside that bank, and every bank receives the same offset. Each bank therefore owns one contiguous slice of the address space: bank 0 holds the lowest slice, and each following bank holds the next slice up. A write changes only the chosen bank. The read data comes from the chosen bank alone. The other banks are released, in the same way as disabled tri-state drivers on a shared data bus. On chip, that shared bus is built as an AND-OR merge.

Each bank stores on the rising clock edge and reads combinationally. A read therefore follows the address with no clock edge in between. The defaults give a 10-bit address and four banks of 256 words of 8 bits. Setting the local address width to 16 gives four banks of 64K x 8, for 256K x 8 in total. While reset is low, every write is held off. The stored contents are never cleared.

Top module: `banked_mem`

## Requirements
- R1: The top BANK_AW bits of addr_i select bank k, and the low LOCAL_AW bits select the word inside it. Bank k therefore holds the addresses k*2^LOCAL_AW through (k+1)*2^LOCAL_AW-1. With the defaults, 0x000-0x0FF is bank 0, 0x100-0x1FF is bank 1, 0x200-0x2FF is bank 2 and 0x300-0x3FF is bank 3.
- R2: Exactly one bank select is active at all times.
- R3: When we_i is high at a rising clk_i edge, wdata_i is stored at addr_i. A later read of that address returns it.
- R4: A write to one bank leaves unchanged the word at the same local offset in every other bank.
- R5: rdata_o follows a change of addr_i within the same clock phase, with no clock edge between them.
- R6: rdata_o equals the content of the selected bank at the local offset. Unselected banks contribute nothing.
- R7: While we_i is low, no stored word changes.
- R8: While rst_ni is low, writes are ignored. Stored words keep their values through reset.
- R9: The last word of one bank and the first word of the next bank are separate locations, each in its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks writes while low |
| addr_i | input | BANK_AW+LOCAL_AW | Full word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | DATA_W | Combinational read data of the addressed word |

## Verification
The hardest fault to expose from the ports is aliasing between banks. Such a fault occurs when a decode error makes two banks share storage, or makes a write land in more than one bank. Every single-address write-then-read looks correct under it. To expose it, the stimulus writes a distinct value at one local offset in every bank, then reads all of them back. It does the same across the edges between adjacent banks. Random traffic then mixes writes and reads against a reference model indexed by the full address. Any leak across banks shows up as a mismatch at a different bank's address.

// File: rtl/banked_mem_pkg.sv
`timescale 1ns/1ps
package banked_mem_pkg;
  localparam int unsigned BM_DATA_W   = 8;
  localparam int unsigned BM_LOCAL_AW = 8;
  localparam int unsigned BM_BANK_AW  = 2;

  function automatic int unsigned bm_num_banks(input int unsigned bank_aw);
    return 32'd1 << bank_aw;
  endfunction
endpackage

// File: rtl/bm_bank_decode.sv
`timescale 1ns/1ps
module bm_bank_decode #(
  parameter int unsigned BANK_AW   = 2,
  parameter int unsigned NUM_BANKS = 1 << BANK_AW
) (
  input  logic [BANK_AW-1:0]   idx_i,
  output logic [NUM_BANKS-1:0] sel_o
);
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_sel
    assign sel_o[k] = (idx_i == BANK_AW'(k));
  end
endmodule

// File: rtl/bm_ram_bank.sv
`timescale 1ns/1ps
module bm_ram_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/bm_read_merge.sv
`timescale 1ns/1ps
module bm_read_merge #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic [NUM_BANKS-1:0]             sel_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]                data_o
);
  // AND-OR stand-in for a shared tri-state bus
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      data_o = data_o | (data_i[k] & {DATA_W{sel_i[k]}});
    end
  end
endmodule

// File: rtl/banked_mem.sv
`timescale 1ns/1ps
module banked_mem
  import banked_mem_pkg::*;
#(
  parameter int unsigned DATA_W   = BM_DATA_W,
  parameter int unsigned LOCAL_AW = BM_LOCAL_AW,
  parameter int unsigned BANK_AW  = BM_BANK_AW
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [BANK_AW+LOCAL_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        we_i,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned NUM_BANKS = bm_num_banks(BANK_AW);
  localparam int unsigned ADDR_W    = BANK_AW + LOCAL_AW;

  logic [BANK_AW-1:0]              bank_idx;
  logic [LOCAL_AW-1:0]             local_addr;
  logic [NUM_BANKS-1:0]            bank_sel;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                            wr_en;

  assign bank_idx   = addr_i[ADDR_W-1:LOCAL_AW];
  assign local_addr = addr_i[LOCAL_AW-1:0];
  assign wr_en      = we_i & rst_ni;

  bm_bank_decode #(
    .BANK_AW  (BANK_AW),
    .NUM_BANKS(NUM_BANKS)
  ) u_decode (
    .idx_i(bank_idx),
    .sel_o(bank_sel)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    bm_ram_bank #(
      .DATA_W(DATA_W),
      .AW    (LOCAL_AW)
    ) u_bank (
      .clk_i  (clk_i),
      .we_i   (wr_en & bank_sel[k]),
      .addr_i (local_addr),
      .wdata_i(wdata_i),
      .rdata_o(bank_rdata[k])
    );
  end

  bm_read_merge #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_merge (
    .sel_i (bank_sel),
    .data_i(bank_rdata),
    .data_o(rdata_o)
  );
endmodule

// File: rtl/bm_checker.sv
`timescale 1ns/1ps
module bm_checker #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOCAL_AW = 8,
  parameter int unsigned BANK_AW  = 2
) (
  input logic                                        clk_i,
  input logic                                        rst_ni,
  input logic [BANK_AW+LOCAL_AW-1:0]                 addr_i,
  input logic [DATA_W-1:0]                           wdata_i,
  input logic                                        we_i,
  input logic [DATA_W-1:0]                           rdata_o,
  input logic [(1<<BANK_AW)-1:0]                     bank_sel,
  input logic [(1<<BANK_AW)-1:0][DATA_W-1:0]         bank_rdata
);
  localparam int unsigned ADDR_W = BANK_AW + LOCAL_AW;

  assert_one_bank_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bank_sel) == 1);

  assert_write_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ($stable(addr_i) -> (rdata_o == $past(wdata_i))));

  assert_merge_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o == bank_rdata[addr_i[ADDR_W-1:LOCAL_AW]]);

  assert_no_write_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(addr_i) -> $stable(rdata_o)));
endmodule

bind banked_mem bm_checker #(
  .DATA_W  (DATA_W),
  .LOCAL_AW(LOCAL_AW),
  .BANK_AW (BANK_AW)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .bank_sel  (bank_sel),
  .bank_rdata(bank_rdata)
);

// File: tb/banked_mem_tb_top.sv
`timescale 1ns/1ps
module banked_mem_tb_top;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned LOCAL_AW = 8;
  localparam int unsigned BANK_AW  = 2;
  localparam int unsigned ADDR_W   = BANK_AW + LOCAL_AW;
  localparam int unsigned TOTAL    = 1 << ADDR_W;
  localparam int unsigned DEPTH    = 1 << LOCAL_AW;
  localparam int unsigned NBANK    = 1 << BANK_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model [TOTAL];
  bit                valid [TOTAL];

  always #5 clk = ~clk;

  banked_mem #(.DATA_W(DATA_W), .LOCAL_AW(LOCAL_AW), .BANK_AW(BANK_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata)
  );

  function automatic int unsigned full_addr(input int unsigned bank, input int unsigned off);
    return bank * DEPTH + off;
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (rst_n) begin
      model[a] = d;
      valid[a] = 1'b1;
    end
  endtask

  task automatic rd_check(input string tag, input int unsigned a);
    @(negedge clk);
    addr = ADDR_W'(a); we = 1'b0;
    #1;
    check(tag, rdata, model[a]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < TOTAL; i++) valid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 / R1: same offset in every bank, distinct patterns
    for (int b = 0; b < NBANK; b++) wr(full_addr(b, 8'h3C), DATA_W'(8'hA0 + b * 8'h11));
    for (int b = 0; b < NBANK; b++) rd_check("R4 same offset isolated", full_addr(b, 8'h3C));
    wr(full_addr(2, 8'h3C), 8'h5A);
    for (int b = 0; b < NBANK; b++) rd_check("R4 rewrite bank2 only", full_addr(b, 8'h3C));

    // R9 / R1: bank edges
    for (int b = 0; b < NBANK; b++) begin
      wr(full_addr(b, 0), DATA_W'(8'h10 + b));
      wr(full_addr(b, DEPTH - 1), DATA_W'(8'hE0 + b));
    end
    for (int b = 0; b < NBANK; b++) begin
      rd_check("R9 first word", full_addr(b, 0));
      rd_check("R9 last word", full_addr(b, DEPTH - 1));
    end
    rd_check("R1 top address", TOTAL - 1);

    // R5: combinational read, two addresses within one low phase
    @(negedge clk);
    addr = ADDR_W'(full_addr(1, 0)); #1;
    check("R5 async read a", rdata, model[full_addr(1, 0)]);
    addr = ADDR_W'(full_addr(3, DEPTH - 1)); #1;
    check("R5 async read b", rdata, model[full_addr(3, DEPTH - 1)]);

    // R7: we low, data changing
    @(negedge clk);
    addr = ADDR_W'(full_addr(0, 8'h3C)); wdata = 8'hFF; we = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R7 no write when we low", rdata, model[full_addr(0, 8'h3C)]);

    // R8: writes blocked during reset, content kept
    wr(full_addr(1, 8'h77), 8'h3E);
    @(negedge clk);
    rst_n = 1'b0;
    wr(full_addr(1, 8'h77), 8'hC1);
    wr(full_addr(1, 8'h77), 8'hC2);
    @(negedge clk);
    rst_n = 1'b1;
    rd_check("R8 write ignored in reset", full_addr(1, 8'h77));
    rd_check("R8 content kept through reset", full_addr(3, 8'h3C));

    // R3 / R6: random traffic
    for (int n = 0; n < 600; n++) begin
      int unsigned a;
      a = $urandom % TOTAL;
      if (n % 3 == 0) a = full_addr($urandom % NBANK, 8'h3C);
      if (($urandom % 2) == 0 || !valid[a]) wr(a, DATA_W'($urandom));
      else rd_check("R3 R6 random read", a);
    end
    for (int b = 0; b < NBANK; b++) rd_check("R6 final sweep", full_addr(b, 8'h3C));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule